// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block guards the completion queue of a bus bridge on its secondary side. A completion that has moved to the head of the queue must be fetched by the master that requested it. The master fetches it by repeating its transaction. If that repeat does not arrive within a programmable window, the block emits a one-clock discard pulse so that the queue can drop the stale completion.

The block also holds a 16-bit control register. One field picks a short or a long window. A sticky status flag records that an expiry happened. A second enable turns each expiry into a one-clock system-error pulse on the primary side. Two further bits are plain storage that the surrounding logic may use: a parity-to-system-error enable and a legacy primary-timer bit that has no effect here.

The register has one address, so it has no address input. Writes take effect per byte lane, and the current value is always visible on the readback port.

Top module: `dt_discard_timer`

## Requirements
- R1: After reset, the readback is 0000h and neither the discard pulse nor the system-error pulse is asserted.
- R2: A head-of-queue strobe sampled at clock edge k arms the countdown. With no retry, the discard output is high for exactly one cycle: the cycle between edges k+N-1 and k+N, where N is the window length.
- R3: Bit 0 (window select) sets the window length: 1 gives N = 2^10 clocks and 0 gives N = 2^15 clocks. The value of the bit at the arming edge is the one that applies.
- R4: A retry strobe while the countdown is armed stops and clears it. This includes a retry in the final cycle, which suppresses the discard in that same cycle. No discard follows until the next head strobe.
- R5: A head strobe while the countdown is armed restarts a full window. If a head strobe and a retry arrive in the same cycle, the head strobe wins and the countdown is armed.
- R6: Bit 1 (expiry status) becomes 1 at the edge that ends a discard cycle and stays 1 until cleared. A write with lane 0 enabled and data bit 1 = 1 clears it. If an expiry and a clearing write fall on the same edge, the status stays 1.
- R7: The system-error output equals the discard output when bit 2 (error enable) is 1. When bit 2 is 0, the system-error output stays low.
- R8: Bit 9 (parity-to-system-error enable) and bit 8 (legacy primary-timer bit) read back what was written. Neither changes the timing of the countdown.
- R9: Bit 3 reads 0 whatever is written to it, and bits 15:10 and 7:4 also read 0.
- R10: Byte enable bit 0 gates writes to bits 7:0, and byte enable bit 1 gates writes to bits 15:8. A write with a lane disabled leaves that lane's fields unchanged.
- R11: With no head strobe since reset, or since the countdown last ended, no discard is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | One-cycle strobe: a delayed completion reached the queue head |
| retry | input | 1 | One-cycle strobe: the requesting master repeated its transaction |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| wr_be | input | 2 | Byte lane enables for the write |
| discard | output | 1 | One-cycle pulse: drop the head completion |
| serr_pulse | output | 1 | One-cycle system-error pulse toward the primary side |
| rd_data | output | 16 | Current register value |

## Verification
The bench lets full windows run out in both the short and the long setting. This shows that the window length is right and that the select bit applies as sampled at arming. Retries are placed in the middle of a window and on its very last cycle; the last-cycle case tells a retry that clears the counter apart from one that arrives after the discard has already been emitted. Head strobes are repeated while the countdown is armed, and a head strobe is given together with a retry, which separates a restart from a continued count. A clearing write is timed onto the expiry edge, and writes are made with each byte lane masked, so that the set-over-clear priority and the lane gating are each exercised on their own.

// File: rtl/dt_pkg.sv
package dt_pkg;
   localparam int REG_W    = 16;
   localparam int B_SHORT  = 0;
   localparam int B_STAT   = 1;
   localparam int B_SERR   = 2;
   localparam int B_FB2B   = 3;
   localparam int B_COMPAT = 8;
   localparam int B_PERR   = 9;
   localparam logic [REG_W-1:0] LIVE_MASK = 16'h0307;

   typedef struct packed {
      logic short_sel;
      logic stat;
      logic serr_en;
      logic compat;
      logic perr_en;
   } ctl_t;
endpackage

// File: rtl/dt_ctl_reg.sv
module dt_ctl_reg
   import dt_pkg::*;
#(
   parameter int W    = 16,
   parameter int BE_W = W / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [W-1:0]    wr_data,
   input  logic [BE_W-1:0] wr_be,
   input  logic            expire,
   output ctl_t            ctl,
   output logic [W-1:0]    rd_data
);
   logic [BE_W-1:0] lane_we;

   initial begin
      assert (W == REG_W) else $error("dt_ctl_reg: width must be %0d", REG_W);
      assert (BE_W * 8 == W) else $error("dt_ctl_reg: width not whole bytes");
   end

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_we[g] = wr_en & wr_be[g];
   end

   logic clr_stat;
   assign clr_stat = lane_we[0] & wr_data[B_STAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (lane_we[0]) begin
            ctl.short_sel <= wr_data[B_SHORT];
            ctl.serr_en   <= wr_data[B_SERR];
         end
         if (lane_we[1]) begin
            ctl.compat  <= wr_data[B_COMPAT];
            ctl.perr_en <= wr_data[B_PERR];
         end
         if (expire)        ctl.stat <= 1'b1;
         else if (clr_stat) ctl.stat <= 1'b0;
      end
   end

   always_comb begin
      rd_data           = '0;
      rd_data[B_SHORT]  = ctl.short_sel;
      rd_data[B_STAT]   = ctl.stat;
      rd_data[B_SERR]   = ctl.serr_en;
      rd_data[B_FB2B]   = 1'b0;
      rd_data[B_COMPAT] = ctl.compat;
      rd_data[B_PERR]   = ctl.perr_en;
   end

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.stat && !clr_stat) |=> ctl.stat); // R6
   AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> ctl.stat); // R6
endmodule

// File: rtl/dt_countdown.sv
module dt_countdown #(
   parameter int LONG_LOG2  = 15,
   parameter int SHORT_LOG2 = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic head,
   input  logic retry,
   input  logic short_sel,
   output logic expire,
   output logic armed
);
   localparam int CW = LONG_LOG2;
   localparam logic [CW-1:0] LOAD_LONG  = {CW{1'b1}};
   localparam logic [CW-1:0] LOAD_SHORT = {{(CW-SHORT_LOG2){1'b0}}, {SHORT_LOG2{1'b1}}};

   initial begin
      assert (SHORT_LOG2 >= 1) else $error("dt_countdown: short window too small");
      assert (SHORT_LOG2 < LONG_LOG2) else $error("dt_countdown: short must be below long");
      assert (LONG_LOG2 <= 30) else $error("dt_countdown: long window too wide");
   end

   logic [CW-1:0] cnt;
   logic          at_zero;
   assign at_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (head) begin
         armed <= 1'b1;
         cnt   <= short_sel ? LOAD_SHORT : LOAD_LONG;
      end else if (retry) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (armed) begin
         if (at_zero) armed <= 1'b0;
         else         cnt   <= cnt - 1'b1;
      end
   end

   assign expire = armed & at_zero & ~retry;

   AST_RETRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (retry && !head) |=> !expire); // R4
   AST_HEAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      head |=> (armed && !expire)); // R5
endmodule

// File: rtl/dt_discard_timer.sv
module dt_discard_timer
   import dt_pkg::*;
#(
   parameter int LONG_LOG2  = 15,
   parameter int SHORT_LOG2 = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        head_valid,
   input  logic        retry,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   input  logic [1:0]  wr_be,
   output logic        discard,
   output logic        serr_pulse,
   output logic [15:0] rd_data
);
   ctl_t ctl;
   logic expire;
   logic armed;

   dt_countdown #(.LONG_LOG2(LONG_LOG2), .SHORT_LOG2(SHORT_LOG2)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .head      (head_valid),
      .retry     (retry),
      .short_sel (ctl.short_sel),
      .expire    (expire),
      .armed     (armed)
   );

   dt_ctl_reg #(.W(REG_W), .BE_W(REG_W / 8)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .wr_be   (wr_be),
      .expire  (expire),
      .ctl     (ctl),
      .rd_data (rd_data)
   );

   assign discard    = expire;
   assign serr_pulse = expire & ctl.serr_en;

   AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      serr_pulse |-> (discard && rd_data[B_SERR])); // R7
   AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      discard |=> !discard); // R2
   AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      discard |=> rd_data[B_STAT]); // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE_MASK) == '0); // R9
endmodule

// File: tb/test_dt_discard_timer.sv
module test_dt_discard_timer;
   localparam int CLK_PERIOD = 10;
   localparam int N_SHORT = 1024;
   localparam int N_LONG  = 32768;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic head_valid = 1'b0, retry = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wr_be = '0;
   logic discard, serr_pulse;
   logic [15:0] rd_data;

   int errors = 0, checks = 0, cycles = 0;
   bit done = 0;

   // behavioural reference state
   int  rem = 0;
   bit  m_short = 0, m_stat = 0, m_serr = 0, m_compat = 0, m_perr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dt_discard_timer i_dt_discard_timer (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .retry(retry),
      .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
      .discard(discard), .serr_pulse(serr_pulse), .rd_data(rd_data)
   );

   function automatic logic [15:0] exp_rd();
      logic [15:0] v = '0;
      v[0] = m_short; v[1] = m_stat; v[2] = m_serr; v[8] = m_compat; v[9] = m_perr;
      return v;
   endfunction

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   task automatic step(input bit hv, input bit rt, input bit we,
                       input logic [15:0] wd, input logic [1:0] be, input string tag);
      bit e_disc;
      head_valid = hv; retry = rt; wr_en = we; wr_data = wd; wr_be = be;
      #1;
      e_disc = (rem == 1) && !rt;
      chk({15'd0, discard}, {15'd0, e_disc}, "discard", tag);
      chk({15'd0, serr_pulse}, {15'd0, e_disc && m_serr}, "serr_pulse", tag);
      chk(rd_data, exp_rd(), "rd_data", tag);
      @(posedge clk);
      if (hv)           rem = m_short ? N_SHORT : N_LONG;
      else if (rt)      rem = 0;
      else if (rem > 0) rem = rem - 1;
      if (we && be[0]) begin m_short = wd[0]; m_serr = wd[2]; end
      if (we && be[1]) begin m_compat = wd[8]; m_perr = wd[9]; end
      if (e_disc) m_stat = 1;
      else if (we && be[0] && wd[1]) m_stat = 0;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, tag);
   endtask

   task automatic wr(input logic [15:0] d, input logic [1:0] be, input string tag);
      step(0, 0, 1, d, be, tag);
   endtask

   task automatic run_to_last(input string tag);
      while (rem != 1) step(0, 0, 0, '0, '0, tag);
   endtask

   always @(posedge clk) cycles++;

   initial begin
      while (!done) begin
         @(posedge clk);
         if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset value and quiet outputs
      chk(rd_data, 16'h0000, "reset rd_data", "R1");
      chk({14'd0, discard, serr_pulse}, 16'h0, "reset pulses", "R1");
      // R11: idle, nothing pending
      idle(40, "R11");
      // R3 R7 R2: short window with error enable, full expiry
      wr(16'h0005, 2'b01, "R3");
      step(1, 0, 0, '0, '0, "R2");
      idle(N_SHORT + 20, "R2");
      // R6: status sticky, then W1C
      idle(10, "R6");
      wr(16'h0007, 2'b01, "R6");
      idle(5, "R6");
      // R4: retry mid-window, then retry on final cycle
      step(1, 0, 0, '0, '0, "R4");
      idle(500, "R4");
      step(0, 1, 0, '0, '0, "R4");
      idle(N_SHORT + 10, "R4");
      step(1, 0, 0, '0, '0, "R4");
      run_to_last("R4");
      step(0, 1, 0, '0, '0, "R4");
      idle(N_SHORT + 10, "R11");
      // R5: restart while armed, head together with retry
      step(1, 0, 0, '0, '0, "R5");
      idle(600, "R5");
      step(1, 0, 0, '0, '0, "R5");
      idle(700, "R5");
      step(1, 1, 0, '0, '0, "R5");
      idle(N_SHORT + 10, "R5");
      // R7: error enable off, discard without serr
      wr(16'h0003, 2'b01, "R7");
      step(1, 0, 0, '0, '0, "R7");
      idle(N_SHORT + 10, "R7");
      // R6: clearing write on the expiry edge, expiry wins
      wr(16'h0007, 2'b01, "R6");
      step(1, 0, 0, '0, '0, "R6");
      run_to_last("R6");
      step(0, 0, 1, 16'h0007, 2'b01, "R6");
      idle(3, "R6");
      // R9 R10: lane gating and read-as-zero bits
      wr(16'hFFFF, 2'b10, "R10");
      idle(2, "R9");
      wr(16'hFFFF, 2'b01, "R9");
      idle(2, "R9");
      wr(16'h0000, 2'b00, "R10");
      wr(16'h0000, 2'b01, "R10");
      idle(2, "R10");
      // R3 R8: long window with storage bits set
      wr(16'h0300, 2'b11, "R8");
      step(1, 0, 0, '0, '0, "R3");
      wr(16'h0001, 2'b01, "R3");
      idle(N_LONG + 20, "R3");
      idle(5, "R8");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule